// File: doc/BRIEF.md
# Asymmetric Burst DMA Channel Engine

A single-channel copy engine that executes a small program fetched from an instruction port. The program first writes a channel control word, a source address and a destination address, then runs a counted loop whose body issues load and store instructions. A load reads a source burst, one 64-bit beat per cycle, into an internal data FIFO. A store writes a destination burst from that FIFO. The source and destination burst lengths may differ, so several loads can be needed to fill the FIFO before one store may begin.

The engine starts at instruction address 0 when reset is released and runs until an end instruction or a fault. It reports the live FIFO level and the highest level seen since reset. The level left over at the end of a program is the static entry requirement. The peak is the dynamic one. The reference program (source burst 1, destination burst 4, four loads and one store per pass, 16 passes) peaks at four entries and leaves none.

Instruction words are 40 bits: opcode in [39:32], immediate in [31:0]. Opcodes: 0x00 end, 0x01 set control word, 0x02 set source address, 0x03 set destination address, 0x04 loop start (immediate = pass count), 0x05 load, 0x06 store, 0x07 loop end. Control word fields: [3:0] source beats minus one, [6:4] log2 of source beat bytes, [11:8] destination beats minus one, [14:12] log2 of destination beat bytes.

Top module: `dma_chan_engine`

## Requirements
- R1: Opcodes 0x01/0x02/0x03 load the control word, source address and destination address. The first read beat uses the programmed source address and the first write beat uses the programmed destination address.
- R2: Each beat advances its address by 2^size bytes, taken from control word bits [6:4] for reads and [14:12] for writes. Addresses carry on across bursts, so with 64-bit beats the addresses step by 8.
- R3: Loop start (0x04) with count N runs the body N times, and loop end (0x07) branches back until the count is used up. A count of 0 runs the body once.
- R4: Every read beat pushes one FIFO entry. A store pops exactly its destination burst length of entries. Written data equals the source data in source address order.
- R5: A store waits, without error, until the FIFO holds at least its destination burst length of entries. No entry is ever popped from an empty FIFO.
- R6: A load waits while the FIFO level, plus beats still in flight, plus its own burst would exceed DEPTH (default 8). The FIFO never overflows.
- R7: fifo_peak holds the largest FIFO level since reset, and never falls below fifo_level. The reference program peaks at 4.
- R8: Once the in-flight beats have landed after an end instruction, fifo_level shows the entries left unstored.
- R9: The end instruction (0x00) raises done for exactly one cycle. After that the engine makes no further read or write beats.
- R10: An opcode above 0x07 raises error, which stays high. The engine halts and done never rises.
- R11: A loop end with no active loop raises error. This includes a second loop end after a loop has completed.
- R12: A load or store whose burst length exceeds DEPTH raises error and moves no data.
- R13: During reset, rd_en, wr_en, done, error, fifo_level, fifo_peak and instr_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_addr | output | PCW (8) | Instruction word index being executed |
| instr_data | input | IW (40) | Instruction word at instr_addr, same cycle |
| rd_en | output | 1 | Read beat request |
| rd_addr | output | AW (32) | Read byte address |
| rd_data | input | DW (64) | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Write beat strobe |
| wr_addr | output | AW (32) | Write byte address |
| wr_data | output | DW (64) | Write data |
| fifo_level | output | LVW (4) | Current FIFO entries |
| fifo_peak | output | LVW (4) | Highest FIFO level since reset |
| done | output | 1 | One-cycle pulse on program end |
| error | output | 1 | Sticky fault flag |

## Verification
The checker watches, on every cycle, the properties that need no program context. These are: the FIFO never overflows or pops empty; the peak never drops below the level and never decreases; consecutive beats step by the beat size; done is a single-cycle pulse with bus silence after it; and error is sticky and excludes done. Several behaviours can only be shown by the bench's whole programs. These are: pass counts and the zero-count case; the order and content of copied data; the peak for each load/store mix; the residual level at end; stalls that last forever when the FIFO cannot satisfy a store or admit a load; and each fault cause.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int OPW  = 8;
  localparam int IMMW = 32;

  typedef enum logic [OPW-1:0] {
    OP_END     = 8'h00,
    OP_SETCTL  = 8'h01,
    OP_SETSRC  = 8'h02,
    OP_SETDST  = 8'h03,
    OP_LOOP    = 8'h04,
    OP_LOAD    = 8'h05,
    OP_STORE   = 8'h06,
    OP_LOOPEND = 8'h07
  } op_e;

  typedef enum logic [1:0] {
    S_RUN,
    S_LOAD,
    S_STORE,
    S_HALT
  } eng_state_e;

  typedef struct packed {
    logic [2:0] dst_size;
    logic [3:0] dst_len;
    logic [2:0] src_size;
    logic [3:0] src_len;
  } chan_ctl_t;

  function automatic chan_ctl_t ctl_from_word(input logic [IMMW-1:0] w);
    chan_ctl_t c;
    c.src_len  = w[3:0];
    c.src_size = w[6:4];
    c.dst_len  = w[11:8];
    c.dst_size = w[14:12];
    return c;
  endfunction

endpackage

// File: rtl/dma_insn_decode.sv
module dma_insn_decode
  import dma_pkg::*;
#(
  parameter int IW = 40
) (
  input  logic [IW-1:0]   insn,
  output op_e             op,
  output logic [IMMW-1:0] imm,
  output logic            illegal
);

  logic [OPW-1:0] raw_op;

  assign raw_op = insn[IW-1 -: OPW];
  assign imm    = insn[IMMW-1:0];

  always_comb begin
    illegal = 1'b0;
    op      = OP_END;
    if (raw_op > OPW'(OP_LOOPEND)) begin
      illegal = 1'b1;
    end else begin
      op = op_e'(raw_op);
    end
  end

endmodule

// File: rtl/dma_data_fifo.sv
module dma_data_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [DW-1:0]  din,
  input  logic           pop,
  output logic [DW-1:0]  dout,
  output logic [LVW-1:0] level,
  output logic [LVW-1:0] peak
);

  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wptr, rptr;
  logic [LVW-1:0] level_nx;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) dout <= mem[rptr];
  end

  always_comb begin
    level_nx = level;
    if (push && !pop)      level_nx = level + LVW'(1);
    else if (pop && !push) level_nx = level - LVW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      peak  <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      level <= level_nx;
      if (level_nx > peak) peak <= level_nx;
    end
  end

endmodule

// File: rtl/dma_loop_ctl.sv
module dma_loop_ctl #(
  parameter int PCW = 8,
  parameter int LCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic [LCW-1:0] arm_count,
  input  logic [PCW-1:0] arm_pc,
  input  logic           close,
  output logic           active,
  output logic           again,
  output logic [PCW-1:0] target_pc
);

  logic [LCW-1:0] remain;

  assign again = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remain    <= '0;
      target_pc <= '0;
    end else if (arm) begin
      active    <= 1'b1;
      remain    <= (arm_count == '0) ? '0 : arm_count - LCW'(1);
      target_pc <= arm_pc;
    end else if (close) begin
      if (remain != '0) remain <= remain - LCW'(1);
      else              active <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int PCW   = 8,
  parameter int IW    = 40,
  parameter int LCW   = 16,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PCW-1:0] instr_addr,
  input  logic [IW-1:0]  instr_data,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [DW-1:0]  wr_data,
  output logic [LVW-1:0] fifo_level,
  output logic [LVW-1:0] fifo_peak,
  output logic           done,
  output logic           error
);

  eng_state_e      state;
  chan_ctl_t       ctl_q;
  logic [PCW-1:0]  pc;
  logic [AW-1:0]   sar, dar;
  logic [4:0]      beats_left;
  logic            rd_pend;

  op_e             dec_op;
  logic [IMMW-1:0] dec_imm;
  logic            dec_illegal;

  logic            loop_arm, loop_close, loop_active, loop_again;
  logic [PCW-1:0]  loop_target;

  logic            fifo_push, fifo_pop;
  logic [4:0]      src_beats, dst_beats;
  logic [AW-1:0]   src_bytes, dst_bytes;
  logic [31:0]     load_need;
  logic            load_fits, store_ready, src_too_long, dst_too_long;
  logic            run_ok;

  assign instr_addr = pc;

  dma_insn_decode #(.IW(IW)) u_dec (
    .insn    (instr_data),
    .op      (dec_op),
    .imm     (dec_imm),
    .illegal (dec_illegal)
  );

  assign run_ok     = (state == S_RUN) && !dec_illegal;
  assign loop_arm   = run_ok && (dec_op == OP_LOOP);
  assign loop_close = run_ok && (dec_op == OP_LOOPEND) && loop_active;

  dma_loop_ctl #(.PCW(PCW), .LCW(LCW)) u_loop (
    .clk       (clk),
    .rst       (rst),
    .arm       (loop_arm),
    .arm_count (dec_imm[LCW-1:0]),
    .arm_pc    (pc + PCW'(1)),
    .close     (loop_close),
    .active    (loop_active),
    .again     (loop_again),
    .target_pc (loop_target)
  );

  assign fifo_push = rd_pend;
  assign fifo_pop  = (state == S_STORE);

  dma_data_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   (rd_data),
    .pop   (fifo_pop),
    .dout  (wr_data),
    .level (fifo_level),
    .peak  (fifo_peak)
  );

  // burst geometry from the control word
  assign src_beats = {1'b0, ctl_q.src_len} + 5'd1;
  assign dst_beats = {1'b0, ctl_q.dst_len} + 5'd1;
  assign src_bytes = AW'(1) << ctl_q.src_size;
  assign dst_bytes = AW'(1) << ctl_q.dst_size;

  // admission: count entries already promised by beats in flight
  assign load_need    = 32'(fifo_level) + 32'(rd_en) + 32'(rd_pend) + 32'(src_beats);
  assign load_fits    = (load_need <= 32'(DEPTH));
  assign store_ready  = (32'(fifo_level) >= 32'(dst_beats));
  assign src_too_long = (32'(src_beats) > 32'(DEPTH));
  assign dst_too_long = (32'(dst_beats) > 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_RUN;
      pc         <= '0;
      ctl_q      <= '{dst_size: 3'd3, dst_len: 4'd0, src_size: 3'd3, src_len: 4'd0};
      sar        <= '0;
      dar        <= '0;
      beats_left <= '0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      rd_pend    <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      done    <= 1'b0;
      rd_pend <= rd_en;
      case (state)
        S_RUN: begin
          if (dec_illegal) begin
            error <= 1'b1;
            state <= S_HALT;
          end else begin
            case (dec_op)
              OP_SETCTL: begin
                ctl_q <= ctl_from_word(dec_imm);
                pc    <= pc + PCW'(1);
              end
              OP_SETSRC: begin
                sar <= AW'(dec_imm);
                pc  <= pc + PCW'(1);
              end
              OP_SETDST: begin
                dar <= AW'(dec_imm);
                pc  <= pc + PCW'(1);
              end
              OP_LOOP: pc <= pc + PCW'(1);
              OP_LOOPEND: begin
                if (!loop_active) begin
                  error <= 1'b1;
                  state <= S_HALT;
                end else begin
                  pc <= loop_again ? loop_target : pc + PCW'(1);
                end
              end
              OP_LOAD: begin
                if (src_too_long) begin
                  error <= 1'b1;
                  state <= S_HALT;
                end else if (load_fits) begin
                  beats_left <= src_beats;
                  state      <= S_LOAD;
                  pc         <= pc + PCW'(1);
                end
              end
              OP_STORE: begin
                if (dst_too_long) begin
                  error <= 1'b1;
                  state <= S_HALT;
                end else if (store_ready) begin
                  beats_left <= dst_beats;
                  state      <= S_STORE;
                  pc         <= pc + PCW'(1);
                end
              end
              default: begin
                done  <= 1'b1;
                state <= S_HALT;
              end
            endcase
          end
        end
        S_LOAD: begin
          rd_en      <= 1'b1;
          rd_addr    <= sar;
          sar        <= sar + src_bytes;
          beats_left <= beats_left - 5'd1;
          if (beats_left == 5'd1) state <= S_RUN;
        end
        S_STORE: begin
          wr_en      <= 1'b1;
          wr_addr    <= dar;
          dar        <= dar + dst_bytes;
          beats_left <= beats_left - 5'd1;
          if (beats_left == 5'd1) state <= S_RUN;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_en,
  input logic [AW-1:0]  rd_addr,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic           done,
  input logic           error,
  input logic [LVW-1:0] level,
  input logic [LVW-1:0] peak,
  input logic           push,
  input logic           pop,
  input logic [2:0]     src_size,
  input logic [2:0]     dst_size
);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
    32'(level) <= 32'(DEPTH));

  p_push_room_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (32'(level) < 32'(DEPTH)) || pop);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> level != '0);

  p_peak_covers_r7: assert property (@(posedge clk) disable iff (rst)
    level <= peak);

  p_peak_hold_r7: assert property (@(posedge clk) disable iff (rst)
    peak >= $past(peak));

  p_rd_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> rd_addr == $past(rd_addr) + (AW'(1) << src_size));

  p_wr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + (AW'(1) << dst_size));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_quiet_after_end_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !rd_en && !wr_en);

  p_error_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  p_error_no_done_r10: assert property (@(posedge clk) disable iff (rst)
    error |-> !done);

endmodule

bind dma_chan_engine dma_chan_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .done     (done),
  .error    (error),
  .level    (fifo_level),
  .peak     (fifo_peak),
  .push     (fifo_push),
  .pop      (fifo_pop),
  .src_size (ctl_q.src_size),
  .dst_size (ctl_q.dst_size)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

  localparam int AW = 32, DW = 64, DEPTH = 8, PCW = 8, IW = 40, LVW = 4;
  localparam logic [31:0] SRC0 = 32'h1000, DST0 = 32'h4000;

  // scenario table: passes, loads, src beats, stores, dst beats, expected peak
  localparam int NSC = 6;
  localparam int TBL [NSC][6] = '{
    '{16, 4, 1, 1, 4, 4},
    '{ 8, 2, 2, 1, 4, 4},
    '{ 4, 1, 4, 1, 4, 4},
    '{ 3, 8, 1, 1, 8, 8},
    '{ 5, 1, 1, 1, 1, 1},
    '{ 0, 1, 2, 1, 2, 2}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PCW-1:0] instr_addr;
  logic [IW-1:0]  instr_data;
  logic           rd_en, wr_en, done, error;
  logic [AW-1:0]  rd_addr, wr_addr;
  logic [DW-1:0]  rd_data = '0;
  logic [DW-1:0]  wr_data;
  logic [LVW-1:0] fifo_level, fifo_peak;

  logic [IW-1:0]  prog [0:255];
  int n_cmp = 0, n_bad = 0;
  int wr_cnt, rd_cnt, done_cnt, bad_beats;
  logic [31:0] first_rd;
  bit fin = 0;

  always #10 clk = ~clk;

  dma_chan_engine dut (
    .clk(clk), .rst(rst), .instr_addr(instr_addr), .instr_data(instr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_level(fifo_level), .fifo_peak(fifo_peak), .done(done), .error(error)
  );

  assign instr_data = prog[instr_addr];

  function automatic logic [DW-1:0] srcword(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  function automatic logic [IW-1:0] ins(input logic [7:0] op, input logic [31:0] imm);
    return {op, imm};
  endfunction

  function automatic logic [31:0] ctlw(input int sb, input int db);
    return (32'd3 << 12) | (32'(db - 1) << 8) | (32'd3 << 4) | 32'(sb - 1);
  endfunction

  // memory model: read data one cycle after the request
  always @(posedge clk) if (rd_en) rd_data <= srcword(rd_addr);

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (rd_en) begin
        if (rd_cnt == 0) first_rd = rd_addr;
        rd_cnt++;
      end
      if (wr_en) begin
        if (wr_addr !== DST0 + 32'(8 * wr_cnt) ||
            wr_data !== srcword(SRC0 + 32'(8 * wr_cnt))) bad_beats++;
        wr_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0; bad_beats = 0; first_rd = '0;
    for (int i = 0; i < 256; i++) prog[i] = ins(8'h00, 32'h0);
  endtask

  task automatic release_run(input int lim);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < lim && done_cnt == 0 && !error; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int p;
    // reset state
    begin_prog();
    repeat (2) @(negedge clk);
    chk("R13 rd_en", 64'(rd_en), 0);
    chk("R13 wr_en", 64'(wr_en), 0);
    chk("R13 done", 64'(done), 0);
    chk("R13 error", 64'(error), 0);
    chk("R13 level", 64'(fifo_level), 0);
    chk("R13 peak", 64'(fifo_peak), 0);
    chk("R13 pc", 64'(instr_addr), 0);

    // table-driven programs
    for (int s = 0; s < NSC; s++) begin
      int passes;
      begin_prog();
      p = 0;
      prog[p] = ins(8'h01, ctlw(TBL[s][2], TBL[s][4])); p = p + 1;
      prog[p] = ins(8'h02, SRC0); p = p + 1;
      prog[p] = ins(8'h03, DST0); p = p + 1;
      prog[p] = ins(8'h04, 32'(TBL[s][0])); p = p + 1;
      for (int j = 0; j < TBL[s][1]; j++) begin prog[p] = ins(8'h05, 0); p = p + 1; end
      for (int j = 0; j < TBL[s][3]; j++) begin prog[p] = ins(8'h06, 0); p = p + 1; end
      prog[p] = ins(8'h07, 0); p = p + 1;
      prog[p] = ins(8'h00, 0);
      release_run(4000);
      passes = (TBL[s][0] == 0) ? 1 : TBL[s][0];
      chk("R9 done pulse count", 64'(done_cnt), 1);
      chk("R10 no error", 64'(error), 0);
      chk("R3 beats written", 64'(wr_cnt), 64'(passes * TBL[s][1] * TBL[s][2]));
      chk("R3 beats read", 64'(rd_cnt), 64'(passes * TBL[s][1] * TBL[s][2]));
      chk("R2 R4 beat address/data mismatches", 64'(bad_beats), 0);
      chk("R1 first read address", 64'(first_rd), 64'(SRC0));
      chk("R7 peak", 64'(fifo_peak), 64'(TBL[s][5]));
      chk("R8 residual level", 64'(fifo_level), 0);
    end

    // R8: leftover entries at end
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 4)); prog[1] = ins(8'h02, SRC0); prog[2] = ins(8'h03, DST0);
    prog[3] = ins(8'h05, 0); prog[4] = ins(8'h05, 0); prog[5] = ins(8'h05, 0);
    prog[6] = ins(8'h00, 0);
    release_run(200);
    chk("R9 done once", 64'(done_cnt), 1);
    chk("R8 leftover level", 64'(fifo_level), 3);
    chk("R7 leftover peak", 64'(fifo_peak), 3);

    // R5: store waits on a short FIFO forever, no error
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 4)); prog[1] = ins(8'h02, SRC0); prog[2] = ins(8'h03, DST0);
    prog[3] = ins(8'h05, 0); prog[4] = ins(8'h05, 0); prog[5] = ins(8'h05, 0);
    prog[6] = ins(8'h06, 0); prog[7] = ins(8'h00, 0);
    release_run(200);
    chk("R5 stalled store writes", 64'(wr_cnt), 0);
    chk("R5 stalled no done", 64'(done_cnt), 0);
    chk("R5 stalled no error", 64'(error), 0);
    chk("R5 stalled level", 64'(fifo_level), 3);

    // R6: ninth load waits on a full FIFO
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 8)); prog[1] = ins(8'h02, SRC0); prog[2] = ins(8'h03, DST0);
    for (int j = 0; j < 9; j++) prog[3 + j] = ins(8'h05, 0);
    prog[12] = ins(8'h06, 0); prog[13] = ins(8'h00, 0);
    release_run(300);
    chk("R6 reads before full", 64'(rd_cnt), 8);
    chk("R6 level full", 64'(fifo_level), 8);
    chk("R6 no error", 64'(error), 0);
    chk("R6 no done", 64'(done_cnt), 0);

    // R10: unknown opcode
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 1)); prog[1] = ins(8'h3F, 0); prog[2] = ins(8'h00, 0);
    release_run(100);
    repeat (20) @(negedge clk);
    chk("R10 error raised and held", 64'(error), 1);
    chk("R10 no done", 64'(done_cnt), 0);

    // R11: loop end after the loop has finished
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 1)); prog[1] = ins(8'h02, SRC0); prog[2] = ins(8'h03, DST0);
    prog[3] = ins(8'h04, 2); prog[4] = ins(8'h05, 0); prog[5] = ins(8'h06, 0);
    prog[6] = ins(8'h07, 0); prog[7] = ins(8'h07, 0); prog[8] = ins(8'h00, 0);
    release_run(200);
    chk("R11 writes before fault", 64'(wr_cnt), 2);
    chk("R11 error", 64'(error), 1);
    chk("R11 no done", 64'(done_cnt), 0);

    // R12: store burst longer than FIFO
    begin_prog();
    prog[0] = ins(8'h01, ctlw(1, 9)); prog[1] = ins(8'h06, 0); prog[2] = ins(8'h00, 0);
    release_run(100);
    chk("R12 long store error", 64'(error), 1);
    chk("R12 long store no writes", 64'(wr_cnt), 0);

    // R12: load burst longer than FIFO
    begin_prog();
    prog[0] = ins(8'h01, ctlw(12, 1)); prog[1] = ins(8'h05, 0); prog[2] = ins(8'h00, 0);
    release_run(100);
    chk("R12 long load error", 64'(error), 1);
    chk("R12 long load no reads", 64'(rd_cnt), 0);
    chk("R12 long load level", 64'(fifo_level), 0);

    if (!fin) begin
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule